// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between a small group of cores and a shared word store. It gives each core a linked-load and conditional-store pair. A linked load returns a word and arms a reservation on that word's address. A conditional store to the same address writes only if nothing else has written or invalidated the word since the linked load. The store reports 1 when it writes and 0 when it is refused. Software builds atomic swap, fetch-and-add and lock acquisition from this pair by retrying until the flag reads 1.

Each core has one request port that carries four operations: plain load, plain store, linked load and conditional store. All ports may issue in the same cycle, and each request gets one response a cycle later. A shared snoop input brings in stores and invalidations from processors outside the block. Each core also has a broadcast output that carries the address of every write the block commits, so that other monitors can see it. A linked load never appears on the broadcast outputs.

The reservation of each core is a two-state machine with the states IDLE and HELD, plus an address register. The machine moves from IDLE to HELD on a linked load that nothing clears in the same cycle. In HELD, a linked load with no clearing event stays in HELD and takes the new address. The machine moves from HELD to IDLE on any conditional store from its own core, or on a clearing event that matches the watched address. A clearing event is a snoop hit or a write committed by another core.

Events in one cycle are ordered as follows:
1. All reads see memory as it was before the cycle.
2. Snoop events come next.
3. Core writes come last, in ascending core index.

Top module: `llsc_monitor`

## Requirements
- R1: A request with `req_op` = 2'b10 (linked load) returns the addressed word on `rsp_rdata` with `rsp_valid` high in the cycle after the request, and arms that core's reservation on the address.
- R2: With `req_op` = 2'b00 (plain load) the word is returned one cycle later. With 2'b01 (plain store) the word is written and `rsp_rdata` reads 0. `rsp_sc_ok` is 0 for every operation other than a conditional store.
- R3: A request with `req_op` = 2'b11 (conditional store) succeeds when the core holds a reservation on that same address and nothing has cleared it. On success the word is written and `rsp_sc_ok` is 1 one cycle later.
- R4: A conditional store made without a reservation, or to an address other than the reserved one, returns `rsp_sc_ok` = 0 and leaves every word unchanged.
- R5: A snoop (`snp_valid` high) whose address equals the reserved address clears the reservation. A snoop to any other address leaves the reservation in place.
- R6: A write committed by another core, plain or conditional, to the reserved address clears the reservation. A plain store from the core that holds the reservation does not clear it.
- R7: Every conditional store clears the issuing core's reservation, whether it succeeds or fails, so a second conditional store with no new linked load fails.
- R8: A new linked load replaces the core's earlier reservation, and a conditional store to the old address then fails.
- R9: Address 0 can be reserved, written conditionally and cleared by a snoop like any other address.
- R10: A linked load never raises `bc_valid`. Every committed write raises that core's `bc_valid` in the request cycle, with `bc_addr` set to the written address.
- R11: When several cores issue conditional stores to the same reserved address in one cycle, at most one succeeds, and it is the one with the lowest index.
- R12: Events in one cycle follow the order reads, then snoops, then core writes by ascending index:
  - a snoop or a write by another core in the same cycle as a linked load leaves no reservation;
  - a snoop in the same cycle as a conditional store to the same address makes the store fail;
  - when several cores write one word in the same cycle, the value from the highest-index core remains.
- R13: Reset (`rst_n` low) clears every response, every reservation and every word to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_CORES | Request strobe, one bit per core |
| req_op | input | 2*NUM_CORES | Operation per core: 00 load, 01 store, 10 linked load, 11 conditional store |
| req_addr | input | ADDR_W*NUM_CORES | Word address per core |
| req_wdata | input | DATA_W*NUM_CORES | Store data per core |
| snp_valid | input | 1 | External store or invalidation present |
| snp_addr | input | ADDR_W | Address of the external event |
| rsp_valid | output | NUM_CORES | Response strobe, one cycle after the request |
| rsp_rdata | output | DATA_W*NUM_CORES | Read data for loads and linked loads, otherwise 0 |
| rsp_sc_ok | output | NUM_CORES | Conditional store success flag |
| bc_valid | output | NUM_CORES | Write committed this cycle by that core |
| bc_addr | output | ADDR_W*NUM_CORES | Address of the committed write, otherwise 0 |

## Verification
The assertions check the cycle-local rules on every cycle:
- a linked load stays off the broadcast outputs;
- the broadcast address matches the request;
- the success flag of a conditional store agrees with the broadcast one cycle earlier;
- a same-cycle snoop defeats a conditional store;
- two cores never both win the same address.

The bench scenarios cover what needs history, because the outcome depends on what happened several cycles earlier:
- reservations cleared by earlier snoops or remote writes;
- reservations consumed by an earlier conditional store;
- reservations replaced by a later linked load;
- memory contents surviving a refused store;
- the effect of reset on reservations and data.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LINK  = 2'b10,
        OP_COND  = 2'b11
    } llsc_op_e;

    typedef enum logic {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;

endpackage

// File: rtl/llsc_resv_fsm.sv
module llsc_resv_fsm
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_link,
    input  logic              req_cond,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              kill,
    output logic              held,
    output logic [ADDR_W-1:0] held_addr
);

    rsv_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // Transitions; kill is already computed against the address being watched
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            RSV_IDLE: begin
                if (req_link && !kill) begin
                    state_d = RSV_HELD;
                    addr_d  = req_addr;
                end
            end
            RSV_HELD: begin
                if (req_cond || kill) begin
                    state_d = RSV_IDLE;
                end else if (req_link) begin
                    addr_d = req_addr;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        held      = (state_q == RSV_HELD);
        held_addr = addr_q;
    end

endmodule

// File: rtl/llsc_commit_arb.sv
module llsc_commit_arb
    import llsc_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int ADDR_W    = 4
) (
    input  logic [NUM_CORES-1:0]             req_valid,
    input  logic [NUM_CORES-1:0][1:0]        req_op,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0] req_addr,
    input  logic [NUM_CORES-1:0]             held,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0] held_addr,
    input  logic                             snp_valid,
    input  logic [ADDR_W-1:0]                snp_addr,
    output logic [NUM_CORES-1:0]             wr_commit,
    output logic [NUM_CORES-1:0]             cond_ok,
    output logic [NUM_CORES-1:0]             kill
);

    logic [NUM_CORES-1:0]             is_store;
    logic [NUM_CORES-1:0]             is_cond;
    logic [NUM_CORES-1:0]             is_link;
    logic [NUM_CORES-1:0]             snoop_hit;
    logic [NUM_CORES-1:0]             earlier_wr;
    logic [NUM_CORES-1:0][ADDR_W-1:0] watch_addr;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_decode
        assign is_store[g]   = req_valid[g] && (req_op[g] == OP_STORE);
        assign is_cond[g]    = req_valid[g] && (req_op[g] == OP_COND);
        assign is_link[g]    = req_valid[g] && (req_op[g] == OP_LINK);
        assign snoop_hit[g]  = snp_valid && (snp_addr == req_addr[g]);
        assign watch_addr[g] = is_link[g] ? req_addr[g] : held_addr[g];
    end

    // Writes commit in ascending index; a lower index write to the same
    // word in this cycle defeats a conditional store.
    always_comb begin
        wr_commit  = '0;
        cond_ok    = '0;
        earlier_wr = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            for (int j = 0; j < NUM_CORES; j++) begin
                if (j < i && wr_commit[j] && (req_addr[j] == req_addr[i])) begin
                    earlier_wr[i] = 1'b1;
                end
            end
            cond_ok[i]   = is_cond[i] && held[i] && (held_addr[i] == req_addr[i])
                           && !snoop_hit[i] && !earlier_wr[i];
            wr_commit[i] = is_store[i] || cond_ok[i];
        end
    end

    // Clearing events: external snoop or any other core's committed write
    always_comb begin
        kill = '0;
        for (int k = 0; k < NUM_CORES; k++) begin
            kill[k] = snp_valid && (snp_addr == watch_addr[k]);
            for (int j = 0; j < NUM_CORES; j++) begin
                if (j != k && wr_commit[j] && (req_addr[j] == watch_addr[k])) begin
                    kill[k] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/llsc_word_store.sv
module llsc_word_store #(
    parameter int NUM_CORES = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CORES-1:0]             wr_en,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0] wr_addr,
    input  logic [NUM_CORES-1:0][DATA_W-1:0] wr_data,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0] rd_addr,
    output logic [NUM_CORES-1:0][DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    // Later (higher index) nonblocking writes to one word take effect last
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CORES; i++) begin
                if (wr_en[i]) begin
                    mem_q[wr_addr[i]] <= wr_data[i];
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_rd
        assign rd_data[g] = mem_q[rd_addr[g]];
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [2*NUM_CORES-1:0]        req_op,
    input  logic [ADDR_W*NUM_CORES-1:0]   req_addr,
    input  logic [DATA_W*NUM_CORES-1:0]   req_wdata,
    input  logic                          snp_valid,
    input  logic [ADDR_W-1:0]             snp_addr,
    output logic [NUM_CORES-1:0]          rsp_valid,
    output logic [DATA_W*NUM_CORES-1:0]   rsp_rdata,
    output logic [NUM_CORES-1:0]          rsp_sc_ok,
    output logic [NUM_CORES-1:0]          bc_valid,
    output logic [ADDR_W*NUM_CORES-1:0]   bc_addr
);

    logic [NUM_CORES-1:0][1:0]        op_a;
    logic [NUM_CORES-1:0][ADDR_W-1:0] addr_a;
    logic [NUM_CORES-1:0][DATA_W-1:0] wdata_a;
    logic [NUM_CORES-1:0][DATA_W-1:0] rd_a;
    logic [NUM_CORES-1:0][ADDR_W-1:0] held_addr_a;
    logic [NUM_CORES-1:0]             held;
    logic [NUM_CORES-1:0]             is_read;
    logic [NUM_CORES-1:0]             wr_commit;
    logic [NUM_CORES-1:0]             cond_ok;
    logic [NUM_CORES-1:0]             kill;
    logic [NUM_CORES-1:0][DATA_W-1:0] rdata_q;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        assign op_a[g]    = req_op[2*g +: 2];
        assign addr_a[g]  = req_addr[ADDR_W*g +: ADDR_W];
        assign wdata_a[g] = req_wdata[DATA_W*g +: DATA_W];
        assign is_read[g] = req_valid[g] && ((op_a[g] == OP_LOAD) || (op_a[g] == OP_LINK));

        llsc_resv_fsm #(
            .ADDR_W (ADDR_W)
        ) i_resv (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_link  (req_valid[g] && (op_a[g] == OP_LINK)),
            .req_cond  (req_valid[g] && (op_a[g] == OP_COND)),
            .req_addr  (addr_a[g]),
            .kill      (kill[g]),
            .held      (held[g]),
            .held_addr (held_addr_a[g])
        );

        assign rsp_rdata[DATA_W*g +: DATA_W] = rdata_q[g];
        assign bc_addr[ADDR_W*g +: ADDR_W]   = wr_commit[g] ? addr_a[g] : '0;
    end

    llsc_commit_arb #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W)
    ) i_arb (
        .req_valid (req_valid),
        .req_op    (op_a),
        .req_addr  (addr_a),
        .held      (held),
        .held_addr (held_addr_a),
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .wr_commit (wr_commit),
        .cond_ok   (cond_ok),
        .kill      (kill)
    );

    llsc_word_store #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_commit),
        .wr_addr (addr_a),
        .wr_data (wdata_a),
        .rd_addr (addr_a),
        .rd_data (rd_a)
    );

    assign bc_valid = wr_commit;

    // Response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_sc_ok <= '0;
            rdata_q   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_sc_ok <= cond_ok;
            for (int i = 0; i < NUM_CORES; i++) begin
                rdata_q[i] <= is_read[i] ? rd_a[i] : '0;
            end
        end
    end

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int ADDR_W    = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CORES-1:0]        req_valid,
    input logic [2*NUM_CORES-1:0]      req_op,
    input logic [ADDR_W*NUM_CORES-1:0] req_addr,
    input logic                        snp_valid,
    input logic [ADDR_W-1:0]           snp_addr,
    input logic [NUM_CORES-1:0]        rsp_valid,
    input logic [NUM_CORES-1:0]        rsp_sc_ok,
    input logic [NUM_CORES-1:0]        bc_valid,
    input logic [ADDR_W*NUM_CORES-1:0] bc_addr
);

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_per
        AST_LINK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_op[2*i +: 2] == OP_LINK) |-> !bc_valid[i]); // R10

        AST_BC_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            bc_valid[i] |-> (bc_addr[ADDR_W*i +: ADDR_W] == req_addr[ADDR_W*i +: ADDR_W])); // R10

        AST_COND_FLAG_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_op[2*i +: 2] == OP_COND) |=> (rsp_sc_ok[i] == $past(bc_valid[i]))); // R3

        AST_FLAG_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_sc_ok[i] |-> $past(req_valid[i] && req_op[2*i +: 2] == OP_COND)); // R2

        AST_SNOOP_DEFEATS_COND: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_op[2*i +: 2] == OP_COND && snp_valid
             && snp_addr == req_addr[ADDR_W*i +: ADDR_W]) |-> !bc_valid[i]); // R12

        AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] |=> rsp_valid[i]); // R1

        for (genvar j = i + 1; j < NUM_CORES; j++) begin : g_pair
            AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid[i] && req_valid[j]
                 && req_op[2*i +: 2] == OP_COND && req_op[2*j +: 2] == OP_COND
                 && req_addr[ADDR_W*i +: ADDR_W] == req_addr[ADDR_W*j +: ADDR_W])
                |-> ($countones({bc_valid[i], bc_valid[j]}) <= 1)); // R11
        end
    end

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
) i_llsc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .snp_valid (snp_valid),
    .snp_addr  (snp_addr),
    .rsp_valid (rsp_valid),
    .rsp_sc_ok (rsp_sc_ok),
    .bc_valid  (bc_valid),
    .bc_addr   (bc_addr)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;

    localparam int NC = 2;
    localparam int AW = 4;
    localparam int DW = 32;

    localparam logic [1:0] LD = 2'b00;
    localparam logic [1:0] ST = 2'b01;
    localparam logic [1:0] LL = 2'b10;
    localparam logic [1:0] SC = 2'b11;

    typedef struct packed {
        logic          v0;
        logic [1:0]    op0;
        logic [AW-1:0] a0;
        logic [DW-1:0] d0;
        logic          v1;
        logic [1:0]    op1;
        logic [AW-1:0] a1;
        logic [DW-1:0] d1;
        logic          sv;
        logic [AW-1:0] sa;
        logic [1:0]    eok;
        logic [DW-1:0] er0;
        logic [DW-1:0] er1;
        logic [1:0]    ebc;
        logic [7:0]    req;
    } vec_t;

    function automatic vec_t mkv(logic v0, logic [1:0] op0, logic [AW-1:0] a0, logic [DW-1:0] d0,
                                 logic v1, logic [1:0] op1, logic [AW-1:0] a1, logic [DW-1:0] d1,
                                 logic sv, logic [AW-1:0] sa, logic [1:0] eok,
                                 logic [DW-1:0] er0, logic [DW-1:0] er1, logic [1:0] ebc,
                                 logic [7:0] req);
        return '{v0, op0, a0, d0, v1, op1, a1, d1, sv, sa, eok, er0, er1, ebc, req};
    endfunction

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        mkv(1,ST,3,'h11, 1,ST,5,'h22, 0,0, 2'b00,'h0,'h0, 2'b11, 2),   // R2 stores
        mkv(1,LD,3,0,    1,LD,5,0,    0,0, 2'b00,'h11,'h22,2'b00, 2),  // R2 loads
        mkv(1,LL,3,0,    0,LD,0,0,    0,0, 2'b00,'h11,'h0, 2'b00, 1),  // R1 link
        mkv(1,SC,3,'h33, 0,LD,0,0,    0,0, 2'b01,'h0,'h0,  2'b01, 3),  // R3 success
        mkv(1,LD,3,0,    0,LD,0,0,    0,0, 2'b00,'h33,'h0, 2'b00, 3),  // R3 data written
        mkv(1,SC,3,'h44, 0,LD,0,0,    0,0, 2'b00,'h0,'h0,  2'b00, 7),  // R7 consumed
        mkv(1,LD,3,0,    0,LD,0,0,    0,0, 2'b00,'h33,'h0, 2'b00, 4),  // R4 unchanged
        mkv(0,LD,0,0,    1,SC,5,'h55, 0,0, 2'b00,'h0,'h0,  2'b00, 4),  // R4 no link
        mkv(1,LL,3,0,    1,LL,3,0,    0,0, 2'b00,'h33,'h33,2'b00, 11), // R11 both link
        mkv(1,SC,3,'h66, 1,SC,3,'h77, 0,0, 2'b01,'h0,'h0,  2'b01, 11), // R11 core 0 wins
        mkv(1,LD,3,0,    1,LD,3,0,    0,0, 2'b00,'h66,'h66,2'b00, 11), // R11 value
        mkv(1,LL,5,0,    0,LD,0,0,    0,0, 2'b00,'h22,'h0, 2'b00, 5),  // R5
        mkv(0,LD,0,0,    0,LD,0,0,    1,5, 2'b00,'h0,'h0,  2'b00, 5),  // R5 snoop hit
        mkv(1,SC,5,'h88, 0,LD,0,0,    0,0, 2'b00,'h0,'h0,  2'b00, 5),  // R5 fails
        mkv(1,LL,5,0,    0,LD,0,0,    0,0, 2'b00,'h22,'h0, 2'b00, 5),  // R5
        mkv(0,LD,0,0,    0,LD,0,0,    1,6, 2'b00,'h0,'h0,  2'b00, 5),  // R5 snoop miss
        mkv(1,SC,5,'h99, 0,LD,0,0,    0,0, 2'b01,'h0,'h0,  2'b01, 5),  // R5 still held
        mkv(1,LL,7,0,    1,LL,7,0,    0,0, 2'b00,'h0,'h0,  2'b00, 6),  // R6
        mkv(0,LD,0,0,    1,ST,7,'h5,  0,0, 2'b00,'h0,'h0,  2'b10, 6),  // R6 core 1 stores
        mkv(1,SC,7,'h6,  1,SC,7,'h7,  0,0, 2'b10,'h0,'h0,  2'b10, 6),  // R6 remote kill, own kept
        mkv(1,LD,7,0,    1,LD,7,0,    0,0, 2'b00,'h7,'h7,  2'b00, 6),  // R6
        mkv(1,LL,2,0,    0,LD,0,0,    0,0, 2'b00,'h0,'h0,  2'b00, 8),  // R8
        mkv(1,LL,4,0,    0,LD,0,0,    0,0, 2'b00,'h0,'h0,  2'b00, 8),  // R8 replace
        mkv(1,SC,2,'h1,  0,LD,0,0,    0,0, 2'b00,'h0,'h0,  2'b00, 8),  // R8 old addr fails
        mkv(0,LD,0,0,    1,LL,0,0,    0,0, 2'b00,'h0,'h0,  2'b00, 9),  // R9
        mkv(0,LD,0,0,    1,SC,0,'h5A, 0,0, 2'b10,'h0,'h0,  2'b10, 9),  // R9 address 0
        mkv(0,LD,0,0,    1,LD,0,0,    0,0, 2'b00,'h0,'h5A, 2'b00, 9),  // R9
        mkv(0,LD,0,0,    1,LL,0,0,    0,0, 2'b00,'h0,'h5A, 2'b00, 9),  // R9
        mkv(0,LD,0,0,    0,LD,0,0,    1,0, 2'b00,'h0,'h0,  2'b00, 9),  // R9 snoop 0
        mkv(0,LD,0,0,    1,SC,0,'h1,  0,0, 2'b00,'h0,'h0,  2'b00, 9),  // R9 fails
        mkv(1,LL,8,0,    0,LD,0,0,    1,8, 2'b00,'h0,'h0,  2'b00, 12), // R12 snoop with link
        mkv(1,SC,8,'h3,  0,LD,0,0,    0,0, 2'b00,'h0,'h0,  2'b00, 12), // R12
        mkv(1,LL,9,0,    0,LD,0,0,    0,0, 2'b00,'h0,'h0,  2'b00, 12), // R12
        mkv(1,SC,9,'h4,  0,LD,0,0,    1,9, 2'b00,'h0,'h0,  2'b00, 12), // R12 snoop with cond
        mkv(1,ST,10,'h9, 1,LL,10,0,   0,0, 2'b00,'h0,'h0,  2'b01, 12), // R12 write with link
        mkv(0,LD,0,0,    1,SC,10,'h8, 0,0, 2'b00,'h0,'h0,  2'b00, 12), // R12
        mkv(1,ST,11,'h1, 1,ST,11,'h2, 0,0, 2'b00,'h0,'h0,  2'b11, 12), // R12 same word
        mkv(1,LD,11,0,   1,LD,11,0,   0,0, 2'b00,'h2,'h2,  2'b00, 12), // R12 high index lands
        mkv(1,LD,10,0,   1,LD,2,0,    0,0, 2'b00,'h9,'h0,  2'b00, 4)   // R4 failed cond left 2
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NC-1:0]        req_valid = '0;
    logic [2*NC-1:0]      req_op = '0;
    logic [AW*NC-1:0]     req_addr = '0;
    logic [DW*NC-1:0]     req_wdata = '0;
    logic                 snp_valid = 1'b0;
    logic [AW-1:0]        snp_addr = '0;
    logic [NC-1:0]        rsp_valid;
    logic [DW*NC-1:0]     rsp_rdata;
    logic [NC-1:0]        rsp_sc_ok;
    logic [NC-1:0]        bc_valid;
    logic [AW*NC-1:0]     bc_addr;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    llsc_monitor #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) i_llsc_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_sc_ok (rsp_sc_ok),
        .bc_valid  (bc_valid),
        .bc_addr   (bc_addr)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        req_valid = {v.v1, v.v0};
        req_op    = {v.op1, v.op0};
        req_addr  = {v.a1, v.a0};
        req_wdata = {v.d1, v.d0};
        snp_valid = v.sv;
        snp_addr  = v.sa;
    endtask

    task automatic idle();
        req_valid = '0;
        req_op    = '0;
        req_addr  = '0;
        req_wdata = '0;
        snp_valid = 1'b0;
        snp_addr  = '0;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R13: outputs quiet in reset
        check("R13 rsp_valid", DW'(rsp_valid), '0);
        check("R13 rsp_sc_ok", DW'(rsp_sc_ok), '0);
        check("R13 bc_valid", DW'(bc_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[k].req, k);
            drive(VECS[k]);
            #1;
            check({tag, " bc_valid"}, DW'(bc_valid), DW'(VECS[k].ebc));
            @(posedge clk);
            @(negedge clk);
            check({tag, " rsp_valid"}, DW'(rsp_valid), DW'({VECS[k].v1, VECS[k].v0}));
            check({tag, " sc_ok"}, DW'(rsp_sc_ok), DW'(VECS[k].eok));
            check({tag, " rdata0"}, rsp_rdata[DW-1:0], VECS[k].er0);
            check({tag, " rdata1"}, rsp_rdata[2*DW-1:DW], VECS[k].er1);
        end

        // R10: broadcast address of a committed store
        drive(mkv(0,LD,0,0, 1,ST,13,'h3C, 0,0, 2'b00,0,0,2'b10, 10));
        #1;
        check("R10 bc_addr", DW'(bc_addr[2*AW-1:AW]), DW'(13));
        @(posedge clk);
        @(negedge clk);

        // R13: reset drops reservation and clears data
        drive(mkv(1,LL,3,0, 0,LD,0,0, 0,0, 2'b00,0,0,2'b00, 13));
        @(posedge clk);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        check("R13 rsp_valid in reset", DW'(rsp_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(mkv(1,SC,3,'hAB, 0,LD,0,0, 0,0, 2'b00,0,0,2'b00, 13));
        #1;
        check("R13 no reservation bc", DW'(bc_valid), '0);
        @(posedge clk);
        @(negedge clk);
        check("R13 cond fails", DW'(rsp_sc_ok), '0);
        drive(mkv(1,LD,3,0, 1,LD,13,0, 0,0, 2'b00,0,0,2'b00, 13));
        @(posedge clk);
        @(negedge clk);
        check("R13 word0 cleared", rsp_rdata[DW-1:0], '0);
        check("R13 word1 cleared", rsp_rdata[2*DW-1:DW], '0);
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule